// File: doc/BRIEF.md
# Load Return Data Formatter

This block takes the data buffer of a completed load, or of an atomic that returns its old value, and turns it into vector register writes. One operation can fill several destination registers. The buffer is flat and interleaved register by lane, with one 64-bit slot per element. For each destination register the block reads one slot per lane, widens the element to the register width and issues a write strobe. The strobe carries the register index, a per-lane enable and one value per lane. A single-cycle done pulse closes the operation.

The source presents a descriptor with a one-cycle `start_i`. The descriptor gives the operation kind, the register width, the memory element type, the execute mask, the register count and the destination addressing. The block latches the control fields. The data buffer is read live, so the source must hold it steady until done. Stores and non-returning atomics only acknowledge, with no writes. Illegal type and width combinations raise an error flag together with done and produce no writes.

Top module: `ldret_fmt`

## Requirements
- R1: The register width is 32 bits when `wide_i`=0 and 64 bits when `wide_i`=1. Element codes on `mtype_i` are 0=U8, 1=U16, 2=U32, 3=U64, 4=S8, 5=S16, 6=S32, 7=S64, 8=F16, 9=F32, 10=F64. A 64-bit element (codes 3, 7, 10) with a 32-bit register is an error.
- R2: Signed codes are sign-extended to the register width, and unsigned codes are zero-extended. When the register is 32 bits, bits 63:32 of each lane's value are zero.
- R3: `op_i` codes are 0=load, 1=store, 2=returning atomic, 3=non-returning atomic. Codes 1 and 3 give a done pulse one cycle after start, with no write and no error.
- R4: Register k, lane l takes its element from the low bits of buffer slot k*LANES+l, where slot s occupies `buf_i[s*64 +: 64]`.
- R5: A lane whose `mask_i` bit is clear has its `wr_lane_en_o` bit clear and its data field zero.
- R6: With `count_i` <= LIST_THRESH, register k goes to `base_i`+k. Above the threshold it goes to list entry k, `list_i[k*IDX_W +: IDX_W]`.
- R7: For a writing operation, `count_i` times the element byte size above MAX_BYTES, or `count_i` above MAX_REGS, is an error. An error (R1, R7, R8) gives done with `err_o`=1 one cycle after start and no writes.
- R8: F32 into a 32-bit register and F64 into a 64-bit register pass through unchanged. F16, F32 into a 64-bit register, and codes above 10 are errors.
- R9: A writing operation issues one register per cycle, starting the cycle after start is accepted. Done comes the cycle after the last write. `busy_o` is high from acceptance through done, and a start while busy is ignored.
- R10: A writing operation with `count_i`=0 gives done one cycle after start, with no writes and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Descriptor valid, accepted when idle |
| op_i | input | 2 | Operation kind |
| wide_i | input | 1 | Register width select (1 = 64 bits) |
| mtype_i | input | 4 | Memory element type |
| mask_i | input | LANES | Execute mask |
| count_i | input | CNT_W | Destination register count |
| base_i | input | IDX_W | Base register index |
| list_i | input | MAX_REGS*IDX_W | Explicit register list |
| buf_i | input | MAX_REGS*LANES*64 | Returned data buffer, held until done |
| busy_o | output | 1 | Operation in progress |
| wr_valid_o | output | 1 | Register write strobe |
| wr_lane_en_o | output | LANES | Per-lane write enable |
| wr_idx_o | output | IDX_W | Destination register index |
| wr_data_o | output | LANES*64 | Per-lane register value |
| done_o | output | 1 | End-of-operation pulse |
| err_o | output | 1 | Operation rejected, valid with done |

## Verification
The hardest case to reach from the ports is a second start arriving while a multi-register walk is in progress. The stimulus raises start again during the walk with a different descriptor and checks that the walk's register sequence is unchanged. The boundaries of the width limit are also delicate: four 32-bit registers fit, while three 64-bit registers do not. Directed descriptors on both sides of that limit, and on both sides of the list threshold, probe them. Each cycle, the reference model compares the outputs against its queue of expected per-cycle events.

// File: rtl/ldret_pkg.sv
package ldret_pkg;

    localparam int SLOT_W = 64;

    typedef enum logic [1:0] {
        OP_LOAD       = 2'd0,
        OP_STORE      = 2'd1,
        OP_ATOM_RET   = 2'd2,
        OP_ATOM_NORET = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WALK = 2'd1,
        PH_FIN  = 2'd2
    } phase_e;

    localparam logic [3:0] MT_U8  = 4'd0;
    localparam logic [3:0] MT_U16 = 4'd1;
    localparam logic [3:0] MT_U32 = 4'd2;
    localparam logic [3:0] MT_U64 = 4'd3;
    localparam logic [3:0] MT_S8  = 4'd4;
    localparam logic [3:0] MT_S16 = 4'd5;
    localparam logic [3:0] MT_S32 = 4'd6;
    localparam logic [3:0] MT_S64 = 4'd7;
    localparam logic [3:0] MT_F16 = 4'd8;
    localparam logic [3:0] MT_F32 = 4'd9;
    localparam logic [3:0] MT_F64 = 4'd10;

endpackage

// File: rtl/ldret_type_dec.sv
module ldret_type_dec
    import ldret_pkg::*;
#(
    parameter int MAX_REGS  = 4,
    parameter int MAX_BYTES = 16,
    parameter int CNT_W     = 4
) (
    input  logic [1:0]       op_i,
    input  logic             wide_i,
    input  logic [3:0]       mtype_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             writes_o,
    output logic [1:0]       size_o,
    output logic             sgn_o,
    output logic             err_o
);
    logic             type_bad;
    logic             width_bad;
    logic [CNT_W+3:0] total_bytes;

    always_comb begin
        size_o   = 2'd0;
        sgn_o    = 1'b0;
        type_bad = 1'b0;
        case (mtype_i)
            MT_U8:  size_o = 2'd0;
            MT_U16: size_o = 2'd1;
            MT_U32: size_o = 2'd2;
            MT_U64: begin size_o = 2'd3; type_bad = !wide_i; end
            MT_S8:  begin size_o = 2'd0; sgn_o = 1'b1; end
            MT_S16: begin size_o = 2'd1; sgn_o = 1'b1; end
            MT_S32: begin size_o = 2'd2; sgn_o = 1'b1; end
            MT_S64: begin size_o = 2'd3; sgn_o = 1'b1; type_bad = !wide_i; end
            MT_F16: begin size_o = 2'd1; type_bad = 1'b1; end
            MT_F32: begin size_o = 2'd2; type_bad = wide_i; end
            MT_F64: begin size_o = 2'd3; type_bad = !wide_i; end
            default: type_bad = 1'b1;
        endcase
        total_bytes = {4'd0, count_i} << size_o;
        width_bad   = (int'(total_bytes) > MAX_BYTES) || (int'(count_i) > MAX_REGS);
        writes_o    = (op_e'(op_i) == OP_LOAD) || (op_e'(op_i) == OP_ATOM_RET);
        err_o       = writes_o && (type_bad || width_bad);
    end
endmodule

// File: rtl/ldret_lane_ext.sv
module ldret_lane_ext
    import ldret_pkg::*;
(
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [1:0]        size_i,
    input  logic              sgn_i,
    input  logic              wide_i,
    output logic [SLOT_W-1:0] val_o
);
    logic [SLOT_W-1:0] full;

    always_comb begin
        case (size_i)
            2'd0:    full = {{56{sgn_i & slot_i[7]}},  slot_i[7:0]};
            2'd1:    full = {{48{sgn_i & slot_i[15]}}, slot_i[15:0]};
            2'd2:    full = {{32{sgn_i & slot_i[31]}}, slot_i[31:0]};
            default: full = slot_i;
        endcase
        val_o = wide_i ? full : {32'd0, full[31:0]};
    end
endmodule

// File: rtl/ldret_fmt.sv
module ldret_fmt
    import ldret_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int MAX_REGS    = 4,
    parameter int LIST_THRESH = 2,
    parameter int IDX_W       = 8,
    parameter int MAX_BYTES   = 16,
    localparam int CNT_W      = $clog2(MAX_REGS + 1) + 1,
    localparam int BUF_W      = MAX_REGS * LANES * SLOT_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [1:0]                op_i,
    input  logic                      wide_i,
    input  logic [3:0]                mtype_i,
    input  logic [LANES-1:0]          mask_i,
    input  logic [CNT_W-1:0]          count_i,
    input  logic [IDX_W-1:0]          base_i,
    input  logic [MAX_REGS*IDX_W-1:0] list_i,
    input  logic [BUF_W-1:0]          buf_i,
    output logic                      busy_o,
    output logic                      wr_valid_o,
    output logic [LANES-1:0]          wr_lane_en_o,
    output logic [IDX_W-1:0]          wr_idx_o,
    output logic [LANES*SLOT_W-1:0]   wr_data_o,
    output logic                      done_o,
    output logic                      err_o
);
    typedef struct packed {
        phase_e                    ph;
        logic [CNT_W-1:0]          k;
        logic [CNT_W-1:0]          cnt;
        logic                      wide;
        logic [1:0]                size;
        logic                      sgn;
        logic                      err;
        logic                      use_list;
        logic [LANES-1:0]          mask;
        logic [IDX_W-1:0]          base;
        logic [MAX_REGS*IDX_W-1:0] list;
    } st_t;

    st_t st_d, st_q;

    logic       dec_writes;
    logic [1:0] dec_size;
    logic       dec_sgn;
    logic       dec_err;

    ldret_type_dec #(
        .MAX_REGS (MAX_REGS),
        .MAX_BYTES(MAX_BYTES),
        .CNT_W    (CNT_W)
    ) u_dec (
        .op_i    (op_i),
        .wide_i  (wide_i),
        .mtype_i (mtype_i),
        .count_i (count_i),
        .writes_o(dec_writes),
        .size_o  (dec_size),
        .sgn_o   (dec_sgn),
        .err_o   (dec_err)
    );

    always_comb begin
        st_d = st_q;
        case (st_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.k        = '0;
                    st_d.cnt      = count_i;
                    st_d.wide     = wide_i;
                    st_d.size     = dec_size;
                    st_d.sgn      = dec_sgn;
                    st_d.err      = dec_err;
                    st_d.use_list = int'(count_i) > LIST_THRESH;
                    st_d.mask     = mask_i;
                    st_d.base     = base_i;
                    st_d.list     = list_i;
                    if (!dec_writes || dec_err || count_i == '0)
                        st_d.ph = PH_FIN;
                    else
                        st_d.ph = PH_WALK;
                end
            end
            PH_WALK: begin
                if (st_q.k == st_q.cnt - CNT_W'(1))
                    st_d.ph = PH_FIN;
                else
                    st_d.k = st_q.k + CNT_W'(1);
            end
            default: begin
                st_d.ph  = PH_IDLE;
                st_d.err = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o       = st_q.ph != PH_IDLE;
    assign wr_valid_o   = st_q.ph == PH_WALK;
    assign wr_lane_en_o = wr_valid_o ? st_q.mask : '0;
    assign done_o       = st_q.ph == PH_FIN;
    assign err_o        = done_o && st_q.err;
    assign wr_idx_o     = st_q.use_list ? st_q.list[int'(st_q.k)*IDX_W +: IDX_W]
                                        : st_q.base + IDX_W'(st_q.k);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [SLOT_W-1:0] slot;
        logic [SLOT_W-1:0] val;
        assign slot = buf_i[(int'(st_q.k)*LANES + l)*SLOT_W +: SLOT_W];
        ldret_lane_ext u_ext (
            .slot_i(slot),
            .size_i(st_q.size),
            .sgn_i (st_q.sgn),
            .wide_i(st_q.wide),
            .val_o (val)
        );
        assign wr_data_o[l*SLOT_W +: SLOT_W] = wr_lane_en_o[l] ? val : '0;
    end
endmodule

// File: rtl/ldret_fmt_chk.sv
module ldret_fmt_chk #(
    parameter int LANES = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start_i,
    input logic [1:0]             op_i,
    input logic                   wide_i,
    input logic [3:0]             mtype_i,
    input logic [LANES-1:0]       mask_i,
    input logic                   busy_o,
    input logic                   wr_valid_o,
    input logic [LANES-1:0]       wr_lane_en_o,
    input logic [LANES*64-1:0]    wr_data_o,
    input logic                   done_o,
    input logic                   err_o
);
    logic [LANES-1:0] cap_mask;
    logic             cap_wide;
    logic             hi_any;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_mask <= '0;
            cap_wide <= 1'b0;
        end else if (start_i && !busy_o) begin
            cap_mask <= mask_i;
            cap_wide <= wide_i;
        end
    end

    always_comb begin
        hi_any = 1'b0;
        for (int l = 0; l < LANES; l++)
            hi_any = hi_any | (|wr_data_o[l*64+32 +: 32]);
    end

    p_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o |=> busy_o);
    p_wr_in_walk_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> busy_o && !done_o);
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);
    p_lane_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> (wr_lane_en_o & ~cap_mask) == '0);
    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o && !cap_wide |-> !hi_any);
    p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o && !wr_valid_o);
    p_no_write_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o && op_i[0] |=> done_o && !wr_valid_o && !err_o);
    p_half_unsup_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !busy_o && op_i == 2'd0 && mtype_i == 4'd8 |=> done_o && err_o);
endmodule

bind ldret_fmt ldret_fmt_chk #(.LANES(LANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .op_i        (op_i),
    .wide_i      (wide_i),
    .mtype_i     (mtype_i),
    .mask_i      (mask_i),
    .busy_o      (busy_o),
    .wr_valid_o  (wr_valid_o),
    .wr_lane_en_o(wr_lane_en_o),
    .wr_data_o   (wr_data_o),
    .done_o      (done_o),
    .err_o       (err_o)
);

// File: tb/sim_ldret_fmt.sv
module sim_ldret_fmt;
    localparam int LANES = 4;
    localparam int NREG  = 4;
    localparam int IDXW  = 8;
    localparam int CW    = 4;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  start_i = 1'b0;
    logic [1:0]            op_i = '0;
    logic                  wide_i = 1'b0;
    logic [3:0]            mtype_i = '0;
    logic [LANES-1:0]      mask_i = '0;
    logic [CW-1:0]         count_i = '0;
    logic [IDXW-1:0]       base_i = '0;
    logic [NREG*IDXW-1:0]  list_i = '0;
    logic [NREG*LANES*64-1:0] buf_i = '0;
    logic                  busy_o, wr_valid_o, done_o, err_o;
    logic [LANES-1:0]      wr_lane_en_o;
    logic [IDXW-1:0]       wr_idx_o;
    logic [LANES*64-1:0]   wr_data_o;

    ldret_fmt u0 (.*);

    always #10 clk = ~clk;

    typedef struct packed {
        logic                wv;
        logic [LANES-1:0]    en;
        logic [IDXW-1:0]     idx;
        logic [LANES*64-1:0] data;
        logic                dn;
        logic                er;
    } ev_t;

    ev_t   exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    finished = 0;

    function automatic logic [63:0] ref_ext(input logic [63:0] raw, input logic [3:0] mt,
                                            input logic wide);
        logic [63:0] v;
        case (mt)
            4'd0: v = 64'(raw[7:0]);
            4'd1: v = 64'(raw[15:0]);
            4'd2, 4'd9: v = 64'(raw[31:0]);
            4'd4: v = 64'($signed(raw[7:0]));
            4'd5: v = 64'($signed(raw[15:0]));
            4'd6: v = 64'($signed(raw[31:0]));
            default: v = raw;
        endcase
        if (!wide) v[63:32] = '0;
        return v;
    endfunction

    function automatic int ref_bytes(input logic [3:0] mt);
        case (mt)
            4'd0, 4'd4: return 1;
            4'd1, 4'd5, 4'd8: return 2;
            4'd2, 4'd6, 4'd9: return 4;
            default: return 8;
        endcase
    endfunction

    function automatic bit ref_type_bad(input logic [3:0] mt, input logic wide);
        if (mt > 4'd10 || mt == 4'd8) return 1;
        if ((mt == 4'd3 || mt == 4'd7 || mt == 4'd10) && !wide) return 1;
        if (mt == 4'd9 && wide) return 1;
        return 0;
    endfunction

    task automatic fill_buf(input int seed);
        logic [63:0] x;
        x = 64'h9E37_79B9_7F4A_7C15 ^ 64'(seed);
        for (int s = 0; s < NREG*LANES; s++) begin
            x = x * 64'd6364136223846793005 + 64'd1442695040888963407;
            buf_i[s*64 +: 64] = x;
        end
    endtask

    task automatic issue(input string tg, input logic [1:0] op, input logic wide,
                         input logic [3:0] mt, input logic [3:0] mask, input int cnt,
                         input int base, input int l0, input int l1, input int l2,
                         input int l3, input bit poke);
        int  lst[4];
        bit  writes, err;
        ev_t e;
        lst[0] = l0; lst[1] = l1; lst[2] = l2; lst[3] = l3;
        @(posedge clk); #2;
        op_i = op; wide_i = wide; mtype_i = mt; mask_i = mask;
        count_i = CW'(cnt); base_i = IDXW'(base);
        for (int i = 0; i < 4; i++) list_i[i*IDXW +: IDXW] = IDXW'(lst[i]);
        start_i = 1'b1;
        writes = (op == 2'd0) || (op == 2'd2);
        err = writes && (ref_type_bad(mt, wide) || cnt * ref_bytes(mt) > 16 || cnt > NREG);
        @(posedge clk); #2;
        if (poke) begin
            op_i = 2'd1; count_i = 4'd1; base_i = 8'hEE; mask_i = 4'hF;
        end else begin
            start_i = 1'b0;
        end
        if (writes && !err) begin
            for (int k = 0; k < cnt; k++) begin
                e = '0;
                e.wv  = 1'b1;
                e.en  = mask;
                e.idx = (cnt > 2) ? IDXW'(lst[k]) : IDXW'(base + k);
                for (int l = 0; l < LANES; l++)
                    if (mask[l]) e.data[l*64 +: 64] = ref_ext(buf_i[(k*LANES+l)*64 +: 64], mt, wide);
                exp_q.push_back(e);
                tag_q.push_back(tg);
            end
        end
        e = '0; e.dn = 1'b1; e.er = err;
        exp_q.push_back(e);
        tag_q.push_back(tg);
        if (poke) begin
            @(posedge clk); #2;
            start_i = 1'b0;
        end
        while (exp_q.size() > 0) @(posedge clk);
        @(posedge clk);
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            ev_t   e;
            string tg;
            checks++;
            if (exp_q.size() > 0) begin
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                if (wr_valid_o !== e.wv || done_o !== e.dn || err_o !== e.er ||
                    wr_lane_en_o !== e.en || wr_data_o !== e.data ||
                    (e.wv && wr_idx_o !== e.idx)) begin
                    errors++;
                    $display("FAIL %s: act v=%b d=%b e=%b en=%h idx=%0d data=%h exp v=%b d=%b e=%b en=%h idx=%0d data=%h",
                             tg, wr_valid_o, done_o, err_o, wr_lane_en_o, wr_idx_o, wr_data_o,
                             e.wv, e.dn, e.er, e.en, e.idx, e.data);
                end
            end else if (busy_o !== 1'b0 || wr_valid_o !== 1'b0 || done_o !== 1'b0 ||
                         wr_data_o !== '0) begin
                errors++;
                $display("FAIL R9 idle: act busy=%b v=%b d=%b exp busy=0 v=0 d=0",
                         busy_o, wr_valid_o, done_o);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: act running exp finished");
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        fill_buf(1);
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        // R4 R1: U32 into 32-bit register, single register, full mask
        issue("R4", 2'd0, 1'b0, 4'd2, 4'hF, 1, 10, 0, 0, 0, 0, 0);
        // R2 R5 R6: S8 into 32-bit, consecutive registers, partial mask
        issue("R2", 2'd0, 1'b0, 4'd4, 4'b1010, 2, 20, 0, 0, 0, 0, 0);
        fill_buf(2);
        // R2: S16 into 64-bit
        issue("R2", 2'd0, 1'b1, 4'd5, 4'hF, 2, 5, 0, 0, 0, 0, 0);
        // R6: returning atomic, U8 into 64-bit, count above threshold uses list
        issue("R6", 2'd2, 1'b1, 4'd0, 4'b0111, 3, 0, 40, 7, 90, 0, 0);
        // R3: store and non-returning atomic
        issue("R3", 2'd1, 1'b0, 4'd2, 4'hF, 2, 3, 0, 0, 0, 0, 0);
        issue("R3", 2'd3, 1'b1, 4'd3, 4'hF, 4, 3, 0, 0, 0, 0, 0);
        // R7: three 64-bit elements exceed the width limit; four 32-bit fit
        issue("R7", 2'd0, 1'b1, 4'd3, 4'hF, 3, 0, 1, 2, 3, 0, 0);
        issue("R7", 2'd0, 1'b0, 4'd6, 4'b1001, 4, 0, 11, 22, 33, 44, 0);
        issue("R7", 2'd0, 1'b0, 4'd0, 4'hF, 5, 0, 0, 0, 0, 0, 0);
        // R1: 64-bit element with 32-bit register
        issue("R1", 2'd0, 1'b0, 4'd7, 4'hF, 1, 0, 0, 0, 0, 0, 0);
        fill_buf(3);
        // R8: float handling
        issue("R8", 2'd0, 1'b0, 4'd8, 4'hF, 1, 0, 0, 0, 0, 0, 0);
        issue("R8", 2'd0, 1'b0, 4'd9, 4'hF, 2, 60, 0, 0, 0, 0, 0);
        issue("R8", 2'd0, 1'b1, 4'd10, 4'hF, 2, 61, 0, 0, 0, 0, 0);
        issue("R8", 2'd2, 1'b1, 4'd9, 4'hF, 1, 0, 0, 0, 0, 0, 0);
        issue("R8", 2'd0, 1'b1, 4'd12, 4'hF, 1, 0, 0, 0, 0, 0, 0);
        // R9: second start during a walk is ignored
        issue("R9", 2'd0, 1'b1, 4'd1, 4'hF, 4, 0, 3, 4, 5, 6, 1);
        // R10: zero count
        issue("R10", 2'd0, 1'b0, 4'd2, 4'hF, 0, 0, 0, 0, 0, 0, 0);
        // R5: all lanes masked still walks with no enables
        issue("R5", 2'd0, 1'b1, 4'd7, 4'h0, 2, 100, 0, 0, 0, 0, 0);
        repeat (3) @(posedge clk);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule